// File: doc/BRIEF.md
# Configurable Quadrature Decoder Front End

This block conditions the three signals of an incremental rotary sensor (two phase lines in quadrature and an index line) for the position and speed counters behind it. Every pin first passes a two-stage synchronizer. The block then applies per-line polarity inversion, an optional exchange of the two phases and a choice of index source. Each resulting line goes through a glitch filter of programmable length. Edge detection and direction decoding come last.

The outputs are plain control pulses and levels with no handshake. `cnt_pulse` is a one-cycle strobe for each counted edge, and `dir_up` gives the direction that goes with it. `idx_pulse` is a one-cycle strobe on each rising edge of the conditioned index. `miss_flag` is a level that reports a run of invalid transitions. The configuration is a single static word loaded through `cfg_wr`, and a write-protect input blocks loading.

Top module: `qdec_front`

## Requirements
- R1: After reset, every configuration field is zero and `cnt_pulse`, `dir_up`, `idx_pulse` and `miss_flag` are all low.
- R2: A cycle with `cfg_wr` high loads `cfg_wdata` into the configuration word unless `wp_en` is high, in which case the word is unchanged. Field layout: bit0 decoder enable, bit1 position enable, bit2 speed enable, bit3 transparent, bit4 both-phase edges, bit5 invert A, bit6 invert B, bit7 invert index, bit8 swap phases, bit9 index taken from phase B pin, bit10 autocorrection, bits16:11 filter length N, bits20:17 missing threshold M.
- R3: Count and index pulses are produced only while the decoder enable is set together with position enable or speed enable (or both).
- R4: With both-phase edges clear, each edge of conditioned phase A gives one `cnt_pulse`. `dir_up` is 1 when A leads B (sequence AB = 00,10,11,01) and 0 when B leads.
- R5: With both-phase edges set, edges on conditioned A and B each give one `cnt_pulse`: four per quadrature cycle.
- R6: In transparent mode, edges are still filtered and counted, but `dir_up` holds its value.
- R7: Invert A, invert B and invert index each complement their line before decoding. Inverting A alone reverses the decoded direction.
- R8: Swap exchanges the conditioned A and B lines after inversion. With swap set, pin-B edges are counted in single-phase mode, and an A-leading pin sequence decodes as down.
- R9: A line level is accepted only after it has held for N+1 consecutive cycles. A pulse of N cycles is discarded, and a pulse of N+1 cycles gives two edges.
- R10: The index source is the index pin when index-from-B is clear and the phase B pin when it is set. Each rising edge of the conditioned index gives one `idx_pulse`.
- R11: Two edges in a row on the same conditioned phase count as one missing pulse, and an edge on the other phase clears the count. `miss_flag` is high while the count is at least M, provided M is nonzero and autocorrection is set. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration load strobe |
| wp_en | input | 1 | Write protect; blocks configuration loads |
| cfg_wdata | input | 21 | Configuration word (layout in R2) |
| pha_pin | input | 1 | Sensor phase A pin (asynchronous) |
| phb_pin | input | 1 | Sensor phase B pin (asynchronous) |
| idx_pin | input | 1 | Sensor index pin (asynchronous) |
| cnt_pulse | output | 1 | One-cycle strobe per counted edge |
| dir_up | output | 1 | Direction of the latest decoded edge, 1 = up |
| idx_pulse | output | 1 | One-cycle strobe per conditioned index rise |
| miss_flag | output | 1 | Missing-pulse threshold reached |

## Verification
The assertions check on every cycle that write protect freezes the configuration word and that an unprotected load takes the presented data. They also check that no pulse leaves the block while it is not enabled, that transparent mode keeps the direction steady, that `idx_pulse` never lasts two cycles, and that the missing flag stays low without a threshold and autocorrection. The bench scenarios are needed for behaviour that depends on the order of stimulus: the direction from phase order, the count per quadrature cycle in each edge mode, the effect of inversion and swap, the exact N versus N+1 filter boundary, the choice of index source and the run length that raises the missing flag.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int FILT_W = 6;
  localparam int THR_W  = 4;

  typedef struct packed {
    logic [THR_W-1:0]  miss_thr;
    logic [FILT_W-1:0] filt_len;
    logic              autocorr;
    logic              idx_from_b;
    logic              swap_ab;
    logic              inv_idx;
    logic              inv_b;
    logic              inv_a;
    logic              both_edges;
    logic              transp;
    logic              spd_en;
    logic              pos_en;
    logic              dec_en;
  } qdec_cfg_t;

  localparam int CFG_W = $bits(qdec_cfg_t);
endpackage

// File: rtl/qdec_cfg_reg.sv
module qdec_cfg_reg
  import qdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             wp_en,
  input  logic [CFG_W-1:0] cfg_wdata,
  output qdec_cfg_t        cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_wr && !wp_en) cfg_q <= qdec_cfg_t'(cfg_wdata);
  end
endmodule

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= '0;
      else if (s == 0) st[s] <= d;
      else st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int W      = 3,
  parameter int FILT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILT_W-1:0] filt_len,
  input  logic [W-1:0]      raw,
  output logic [W-1:0]      clean
);
  for (genvar c = 0; c < W; c++) begin : g_chan
    logic [FILT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_cnt  <= '0;
        clean[c] <= 1'b0;
      end else if (raw[c] == clean[c]) begin
        run_cnt <= '0;
      end else if (run_cnt == filt_len) begin
        run_cnt  <= '0;
        clean[c] <= raw[c];
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  qdec_cfg_t cfg,
  input  logic      ln_a,
  input  logic      ln_b,
  input  logic      ln_i,
  output logic      cnt_pulse,
  output logic      dir_up,
  output logic      idx_pulse,
  output logic      miss_flag
);
  localparam logic [THR_W-1:0] CNT_MAX = '1;

  logic             prv_a, prv_b, prv_i;
  logic             edg_a, edg_b, rise_i, active;
  logic             last_vld, last_on_b;
  logic [THR_W-1:0] miss_cnt;

  assign active = cfg.dec_en && (cfg.pos_en || cfg.spd_en);
  assign edg_a  = ln_a ^ prv_a;
  assign edg_b  = ln_b ^ prv_b;
  assign rise_i = ln_i && !prv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_a <= 1'b0; prv_b <= 1'b0; prv_i <= 1'b0;
      cnt_pulse <= 1'b0; idx_pulse <= 1'b0; dir_up <= 1'b0;
    end else begin
      prv_a <= ln_a; prv_b <= ln_b; prv_i <= ln_i;
      cnt_pulse <= active && (edg_a || (cfg.both_edges && edg_b));
      idx_pulse <= active && rise_i;
      if (active && !cfg.transp) begin
        if (edg_a && !edg_b)      dir_up <= (ln_a != ln_b);
        else if (edg_b && !edg_a) dir_up <= (ln_a == ln_b);
      end
    end
  end

  // run of same-phase edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_vld  <= 1'b0;
      last_on_b <= 1'b0;
      miss_cnt  <= '0;
    end else if (active && (edg_a || edg_b)) begin
      last_vld  <= 1'b1;
      last_on_b <= edg_b && !edg_a;
      if (edg_a && edg_b) miss_cnt <= '0;
      else if (last_vld && (last_on_b == edg_b)) begin
        if (miss_cnt != CNT_MAX) miss_cnt <= miss_cnt + 1'b1;
      end else miss_cnt <= '0;
    end
  end

  assign miss_flag = cfg.autocorr && (cfg.miss_thr != '0) && (miss_cnt >= cfg.miss_thr);
endmodule

// File: rtl/qdec_front.sv
module qdec_front
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             wp_en,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             pha_pin,
  input  logic             phb_pin,
  input  logic             idx_pin,
  output logic             cnt_pulse,
  output logic             dir_up,
  output logic             idx_pulse,
  output logic             miss_flag
);
  localparam int NLINE = 3;

  qdec_cfg_t        cfg_q;
  logic [NLINE-1:0] pin_s, cond, clean;
  logic             a_pol, b_pol;

  qdec_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wp_en(wp_en),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_q)
  );

  qdec_sync #(.W(NLINE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({idx_pin, phb_pin, pha_pin}), .q(pin_s)
  );

  // polarity first, then phase exchange, then index source
  always_comb begin
    a_pol   = pin_s[0] ^ cfg_q.inv_a;
    b_pol   = pin_s[1] ^ cfg_q.inv_b;
    cond[0] = cfg_q.swap_ab ? b_pol : a_pol;
    cond[1] = cfg_q.swap_ab ? a_pol : b_pol;
    cond[2] = (cfg_q.idx_from_b ? pin_s[1] : pin_s[2]) ^ cfg_q.inv_idx;
  end

  qdec_filter #(.W(NLINE), .FILT_W(FILT_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .filt_len(cfg_q.filt_len), .raw(cond), .clean(clean)
  );

  qdec_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q),
    .ln_a(clean[0]), .ln_b(clean[1]), .ln_i(clean[2]),
    .cnt_pulse(cnt_pulse), .dir_up(dir_up), .idx_pulse(idx_pulse), .miss_flag(miss_flag)
  );
endmodule

// File: rtl/qdec_front_chk.sv
module qdec_front_chk
  import qdec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             wp_en,
  input logic [CFG_W-1:0] cfg_wdata,
  input qdec_cfg_t        cfg_q,
  input logic             cnt_pulse,
  input logic             dir_up,
  input logic             idx_pulse,
  input logic             miss_flag
);
  // R2
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && wp_en) |=> $stable(cfg_q));

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !wp_en) |=> (cfg_q == $past(cfg_wdata)));

  // R3
  cnt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> $past(cfg_q.dec_en && (cfg_q.pos_en || cfg_q.spd_en)));

  // R3
  idx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_pulse |-> $past(cfg_q.dec_en && (cfg_q.pos_en || cfg_q.spd_en)));

  // R6
  transp_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.transp |=> $stable(dir_up));

  // R10
  idx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_pulse |=> !idx_pulse);

  // R11
  miss_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.autocorr || cfg_q.miss_thr == '0) |-> !miss_flag);
endmodule

bind qdec_front qdec_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wp_en(wp_en), .cfg_wdata(cfg_wdata),
  .cfg_q(cfg_q), .cnt_pulse(cnt_pulse), .dir_up(dir_up), .idx_pulse(idx_pulse),
  .miss_flag(miss_flag)
);

// File: tb/tb_qdec_front.sv
`timescale 1ns/1ps
module tb_qdec_front;
  localparam int CW = 21;
  localparam logic [CW-1:0] DEC = 21'd1 << 0, POS = 21'd1 << 1, SPD = 21'd1 << 2,
    TRN = 21'd1 << 3, BOTH = 21'd1 << 4, IVA = 21'd1 << 5, IVI = 21'd1 << 7,
    SWP = 21'd1 << 8, IXB = 21'd1 << 9, AUC = 21'd1 << 10;
  localparam int HOLD = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, wp_en = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic pa = 1'b0, pb = 1'b0, pi = 1'b0;
  logic cnt_pulse, dir_up, idx_pulse, miss_flag;

  int n_cnt = 0, n_up = 0, n_idx = 0;
  int s_cnt, s_up, s_idx;
  int checks = 0, fails = 0;
  int qstate = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qdec_front dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wp_en(wp_en), .cfg_wdata(cfg_wdata),
    .pha_pin(pa), .phb_pin(pb), .idx_pin(pi),
    .cnt_pulse(cnt_pulse), .dir_up(dir_up), .idx_pulse(idx_pulse), .miss_flag(miss_flag)
  );

  always @(negedge clk) if (rst_n) begin
    if (cnt_pulse) begin n_cnt++; if (dir_up) n_up++; end
    if (idx_pulse) n_idx++;
  end

  function automatic logic [CW-1:0] flt(input int n); return CW'(n) << 11; endfunction
  function automatic logic [CW-1:0] thr(input int m); return CW'(m) << 17; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic snap(); s_cnt = n_cnt; s_up = n_up; s_idx = n_idx; endtask

  task automatic wr_cfg(input logic [CW-1:0] v, input bit prot);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v; wp_en = prot;
    @(negedge clk); cfg_wr = 1'b0; wp_en = 1'b0;
    cyc(40); snap();
  endtask

  task automatic steps(input int n, input bit up);
    for (int k = 0; k < n; k++) begin
      qstate = up ? (qstate + 1) % 4 : (qstate + 3) % 4;
      pa = (qstate == 1 || qstate == 2);
      pb = (qstate == 2 || qstate == 3);
      cyc(HOLD);
    end
    cyc(20);
  endtask

  task automatic t_reset();
    chk(!cnt_pulse && !idx_pulse && !miss_flag && !dir_up, "R1 outputs low",
        {cnt_pulse, idx_pulse, miss_flag, dir_up}, 0);
    steps(8, 1'b1);
    chk(n_cnt == 0, "R1 zero config counts nothing", n_cnt, 0);
  endtask

  task automatic t_protect();
    wr_cfg(DEC | POS | flt(2), 1'b1);
    steps(16, 1'b1);
    chk(n_cnt - s_cnt == 0, "R2 protected write ignored", n_cnt - s_cnt, 0);
    wr_cfg(DEC | POS | flt(2), 1'b0);
    steps(16, 1'b1);
    chk(n_cnt - s_cnt == 8, "R2 unprotected write takes effect", n_cnt - s_cnt, 8);
  endtask

  task automatic t_gate();
    wr_cfg(DEC | flt(2), 1'b0);
    steps(16, 1'b1);
    chk(n_cnt - s_cnt == 0, "R3 decoder alone idle", n_cnt - s_cnt, 0);
    wr_cfg(POS | SPD | flt(2), 1'b0);
    steps(16, 1'b1);
    chk(n_cnt - s_cnt == 0, "R3 no decoder enable idle", n_cnt - s_cnt, 0);
    wr_cfg(DEC | SPD | flt(2), 1'b0);
    steps(16, 1'b1);
    chk(n_cnt - s_cnt == 8, "R3 speed enable counts", n_cnt - s_cnt, 8);
  endtask

  task automatic t_dir();
    wr_cfg(DEC | POS | flt(2), 1'b0);
    steps(16, 1'b1);
    chk(n_cnt - s_cnt == 8, "R4 A edges counted", n_cnt - s_cnt, 8);
    chk(n_up - s_up == 8, "R4 A leads is up", n_up - s_up, 8);
    snap();
    steps(16, 1'b0);
    chk(n_cnt - s_cnt == 8, "R4 reverse count", n_cnt - s_cnt, 8);
    chk(n_up - s_up == 0, "R4 B leads is down", n_up - s_up, 0);
    chk(dir_up == 1'b0, "R4 dir level down", dir_up, 0);
  endtask

  task automatic t_both();
    wr_cfg(DEC | POS | BOTH | flt(2), 1'b0);
    steps(16, 1'b1);
    chk(n_cnt - s_cnt == 16, "R5 both-phase edges", n_cnt - s_cnt, 16);
    chk(n_up - s_up == 16, "R5 all up", n_up - s_up, 16);
  endtask

  task automatic t_transp();
    wr_cfg(DEC | POS | flt(2), 1'b0);
    steps(8, 1'b0);
    wr_cfg(DEC | POS | TRN | flt(2), 1'b0);
    steps(16, 1'b1);
    chk(n_cnt - s_cnt == 8, "R6 transparent still counts", n_cnt - s_cnt, 8);
    chk(n_up - s_up == 0, "R6 direction held", n_up - s_up, 0);
  endtask

  task automatic t_inv_swap();
    wr_cfg(DEC | POS | IVA | flt(2), 1'b0);
    steps(16, 1'b1);
    chk(n_cnt - s_cnt == 8, "R7 inverted A counts", n_cnt - s_cnt, 8);
    chk(n_up - s_up == 0, "R7 inverted A reverses", n_up - s_up, 0);
    wr_cfg(DEC | POS | SWP | flt(2), 1'b0);
    steps(16, 1'b1);
    chk(n_cnt - s_cnt == 8, "R8 swapped counts", n_cnt - s_cnt, 8);
    chk(n_up - s_up == 0, "R8 swap reverses", n_up - s_up, 0);
  endtask

  task automatic t_filter();
    pa = 1'b0; pb = 1'b0; qstate = 0;
    wr_cfg(DEC | POS | flt(5), 1'b0);
    pa = 1'b1; cyc(5); pa = 1'b0; cyc(30);
    chk(n_cnt - s_cnt == 0, "R9 pulse of N dropped", n_cnt - s_cnt, 0);
    snap();
    pa = 1'b1; cyc(6); pa = 1'b0; cyc(30);
    chk(n_cnt - s_cnt == 2, "R9 pulse of N+1 kept", n_cnt - s_cnt, 2);
  endtask

  task automatic t_index();
    pi = 1'b0;
    wr_cfg(DEC | POS | flt(2), 1'b0);
    pi = 1'b1; cyc(6); pi = 1'b0; cyc(20);
    chk(n_idx - s_idx == 1, "R10 index pin pulse", n_idx - s_idx, 1);
    wr_cfg(DEC | POS | IXB | flt(2), 1'b0);
    pi = 1'b1; cyc(6); pi = 1'b0; cyc(20);
    chk(n_idx - s_idx == 0, "R10 index pin unused", n_idx - s_idx, 0);
    pb = 1'b1; cyc(6); pb = 1'b0; cyc(20);
    chk(n_idx - s_idx == 1, "R10 index from B pin", n_idx - s_idx, 1);
    pi = 1'b1;
    wr_cfg(DEC | POS | IVI | flt(2), 1'b0);
    pi = 1'b0; cyc(6); pi = 1'b1; cyc(20);
    chk(n_idx - s_idx == 1, "R7 inverted index pulse", n_idx - s_idx, 1);
    pi = 1'b0;
  endtask

  task automatic t_missing();
    wr_cfg(DEC | POS | AUC | thr(3) | flt(2), 1'b0);
    pb = ~pb; cyc(HOLD);
    for (int k = 0; k < 3; k++) begin pa = ~pa; cyc(HOLD); end
    chk(miss_flag == 1'b0, "R11 two misses below threshold", miss_flag, 0);
    pa = ~pa; cyc(HOLD);
    chk(miss_flag == 1'b1, "R11 three misses raise flag", miss_flag, 1);
    pb = ~pb; cyc(HOLD);
    chk(miss_flag == 1'b0, "R11 valid edge clears", miss_flag, 0);
    wr_cfg(DEC | POS | AUC | flt(2), 1'b0);
    for (int k = 0; k < 6; k++) begin pa = ~pa; cyc(HOLD); end
    chk(miss_flag == 1'b0, "R11 zero threshold never", miss_flag, 0);
    wr_cfg(DEC | POS | thr(3) | flt(2), 1'b0);
    for (int k = 0; k < 6; k++) begin pa = ~pa; cyc(HOLD); end
    chk(miss_flag == 1'b0, "R11 autocorrection off", miss_flag, 0);
  endtask

  initial begin
    cyc(4); rst_n = 1'b1; cyc(4);
    t_reset();
    t_protect();
    t_gate();
    t_dir();
    t_both();
    t_transp();
    t_inv_swap();
    t_filter();
    t_index();
    t_missing();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule